// File: doc/BRIEF.md
# Half-Duplex SPI Control-Port Slave

This block lets a host microcontroller talk to an on-chip controller over a four-wire SPI link. The host is always the master. It pulls chip select low and drives the serial clock for the whole transaction. The block adds two handshake outputs to the plain SPI wires. A busy flag tells the host to stop sending. An active-low interrupt request tells the host that a word is waiting to be read. A transaction moves data in only one direction. Its first byte is a command: bit 7 set means the host reads, bit 7 clear means the host writes.

On the chip side, the block moves 32-bit words over two valid/ready channels. Incoming bytes pass through one 8-bit shift register and are packed into a word, most significant byte first. The word is then presented to the internal bus. In the other direction, a word accepted from the internal bus is split into bytes, again most significant byte first, and shifted out on MISO through the same shift register. The serial inputs are synchronised into the system clock domain, and both clock edges are detected there.

Top module: `spi_ctrl_port`

## Requirements
- R1: After reset, irq_n is 1, busy is 0, wr_valid is 0, spi_miso is 0 and rd_ready is 1.
- R2: The first byte after chip select falls is a command, sent MSB first in SPI mode 0. Command bit 7 = 1 selects a read transaction and bit 7 = 0 selects a write transaction.
- R3: In a write transaction, every four data bytes form one word with the first byte in bits 31:24. The word is offered on wr_data with wr_valid = 1 and is held unchanged until wr_ready is seen.
- R4: busy is 1 while a completed word waits for wr_ready. It returns to 0 in the cycle after the accepting clock edge.
- R5: While a read word is pending, irq_n is 0 and rd_ready is 0. A new word is accepted only when the slot is empty.
- R6: In a read transaction, the pending word appears on MISO as four bytes, bits 31:24 first and MSB first within each byte. Each bit is valid before the rising edge that samples it.
- R7: irq_n returns to 1 once the last bit of the fourth byte has been clocked. It falls again when another word is accepted, so several words can be read in one transaction.
- R8: spi_miso stays 0 during the command byte and during write transactions. MOSI data sent during a read transaction produces no write word.
- R9: Raising chip select in the middle of a byte or a word discards the partial byte and the partial word. The next transaction starts with a fresh command byte.
- R10: Raising chip select does not drop a completed write word that is still waiting for wr_ready.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Chip select from the host, active low |
| spi_sclk | input | 1 | Serial clock from the host, idle low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| busy | output | 1 | High while a received word is not yet accepted |
| irq_n | output | 1 | Active-low data-ready request |
| wr_valid | output | 1 | Received word valid on the internal bus |
| wr_ready | input | 1 | Internal bus accepts the received word |
| wr_data | output | 32 | Received word |
| rd_valid | input | 1 | Internal bus offers a word for readback |
| rd_ready | output | 1 | Readback slot is empty |
| rd_data | input | 32 | Word to be read back by the host |

## Verification
The assertions assume the host obeys the handshakes. It never completes a fourth byte while busy is high, and it starts a read only after irq_n has fallen. They also assume each serial clock phase lasts several system clocks, so that the synchroniser sees every edge in order. The directed stimulus holds each SCLK phase for ten system clocks and changes MOSI only while SCLK is low. It waits for irq_n before every read and never sends a new word while a completed one is still held. Words are offered on the read channel only through a handshake that waits for rd_ready.

// File: rtl/spi_cp_pkg.sv
`timescale 1ns/1ps
package spi_cp_pkg;
   // Transaction phase: command byte first, then one data direction.
   typedef enum logic [1:0] {
      PH_CMD = 2'd0,
      PH_WR  = 2'd1,
      PH_RD  = 2'd2
   } phase_t;
endpackage

// File: rtl/spi_cp_sync.sv
`timescale 1ns/1ps
module spi_cp_sync #(
   parameter int             W       = 1,
   parameter int             STAGES  = 2,
   parameter logic [W-1:0]   RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("spi_cp_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [W-1:0] pipe [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
      end else begin
         pipe[0] <= d;
         for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
      end
   end

   assign q = pipe[STAGES-1];
endmodule

// File: rtl/spi_cp_wr_pack.sv
`timescale 1ns/1ps
module spi_cp_wr_pack #(
   parameter int BW = 8,
   parameter int NB = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           clr,
   input  logic           byte_stb,
   input  logic [BW-1:0]  byte_in,
   output logic           wr_valid,
   input  logic           wr_ready,
   output logic [BW*NB-1:0] wr_data,
   output logic           busy
);
   localparam int WW = BW * NB;
   localparam int CW = $clog2(NB);

   generate
      if (NB < 3) begin : g_bad_nb
         $error("spi_cp_wr_pack: NB must be at least 3");
      end
   endgenerate

   logic [WW-BW-1:0] acc;
   logic [CW-1:0]    cnt;
   logic             valid_q;
   logic [WW-1:0]    data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc     <= '0;
         cnt     <= '0;
         valid_q <= 1'b0;
         data_q  <= '0;
      end else begin
         if (valid_q && wr_ready) valid_q <= 1'b0;
         if (clr) begin
            acc <= '0;
            cnt <= '0;
         end else if (byte_stb) begin
            if (cnt == CW'(NB-1)) begin
               data_q  <= {acc, byte_in};
               valid_q <= 1'b1;
               cnt     <= '0;
               acc     <= '0;
            end else begin
               acc <= {acc[WW-2*BW-1:0], byte_in};
               cnt <= cnt + 1'b1;
            end
         end
      end
   end

   assign wr_valid = valid_q;
   assign wr_data  = data_q;
   assign busy     = valid_q;

   // R3: an offered word is held until accepted
   a_r3_word_held: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_data)));

   // R4: busy drops the cycle after the accepting edge
   a_r4_busy_release: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && wr_ready && !byte_stb) |=> !busy);
endmodule

// File: rtl/spi_cp_rd_slot.sv
`timescale 1ns/1ps
module spi_cp_rd_slot #(
   parameter int BW = 8,
   parameter int NB = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             byte_done,
   input  logic             rd_valid,
   output logic             rd_ready,
   input  logic [BW*NB-1:0] rd_data,
   output logic             irq_n,
   output logic [BW-1:0]    cur_byte,
   output logic             word_start,
   output logic             fresh
);
   localparam int WW = BW * NB;
   localparam int CW = $clog2(NB);

   logic [WW-1:0] word;
   logic [CW-1:0] cnt;
   logic          pend;
   logic          fresh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word    <= '0;
         cnt     <= '0;
         pend    <= 1'b0;
         fresh_q <= 1'b0;
      end else begin
         fresh_q <= 1'b0;
         if (!pend && rd_valid) begin
            word    <= rd_data;
            pend    <= 1'b1;
            fresh_q <= 1'b1;
         end
         if (clr) begin
            cnt <= '0;
         end else if (byte_done) begin
            if (cnt == CW'(NB-1)) begin
               cnt <= '0;
               if (pend) pend <= 1'b0;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end

   assign rd_ready   = !pend;
   assign irq_n      = !pend;
   assign cur_byte   = word[BW*(NB-1-int'(cnt)) +: BW];
   assign word_start = (cnt == '0);
   assign fresh      = fresh_q;

   // R5: the request only falls after a word was offered
   a_r5_irq_needs_word: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_n) |-> $past(rd_valid));

   // R7: a pending word stays until a byte of it completes
   a_r7_pending_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_n && !byte_done) |=> !irq_n);
endmodule

// File: rtl/spi_ctrl_port.sv
`timescale 1ns/1ps
module spi_ctrl_port
   import spi_cp_pkg::*;
#(
   parameter int BYTE_W      = 8,
   parameter int WORD_BYTES  = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       spi_cs_n,
   input  logic                       spi_sclk,
   input  logic                       spi_mosi,
   output logic                       spi_miso,
   output logic                       busy,
   output logic                       irq_n,
   output logic                       wr_valid,
   input  logic                       wr_ready,
   output logic [BYTE_W*WORD_BYTES-1:0] wr_data,
   input  logic                       rd_valid,
   output logic                       rd_ready,
   input  logic [BYTE_W*WORD_BYTES-1:0] rd_data
);
   localparam int WORD_W = BYTE_W * WORD_BYTES;
   localparam int BITC_W = $clog2(BYTE_W);

   generate
      if (BYTE_W < 2) begin : g_bad_byte
         $error("spi_ctrl_port: BYTE_W must be at least 2");
      end
   endgenerate

   // serial inputs into the clk domain
   logic [2:0] pins_s;
   spi_cp_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({spi_cs_n, spi_sclk, spi_mosi}),
      .q     (pins_s)
   );

   logic cs_act, sclk_s, mosi_s, sclk_d;
   assign cs_act = ~pins_s[2];
   assign sclk_s = pins_s[1];
   assign mosi_s = pins_s[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_d <= 1'b0;
      else        sclk_d <= sclk_s;
   end

   logic rise, fall;
   assign rise = cs_act &  sclk_s & ~sclk_d;
   assign fall = cs_act & ~sclk_s &  sclk_d;

   phase_t            phase;
   logic [BITC_W-1:0] bitcnt;
   logic [BYTE_W-1:0] shreg;
   logic [BYTE_W-1:0] nxt_byte;
   logic              byte_end;
   logic              wr_stb, rd_done;
   logic [BYTE_W-1:0] rd_byte;
   logic              rd_word_start, rd_fresh;

   assign nxt_byte = {shreg[BYTE_W-2:0], mosi_s};
   assign byte_end = rise && (bitcnt == BITC_W'(BYTE_W-1));
   assign wr_stb   = byte_end && (phase == PH_WR);
   assign rd_done  = byte_end && (phase == PH_RD);

   spi_cp_wr_pack #(.BW(BYTE_W), .NB(WORD_BYTES)) u_pack (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (~cs_act),
      .byte_stb (wr_stb),
      .byte_in  (nxt_byte),
      .wr_valid (wr_valid),
      .wr_ready (wr_ready),
      .wr_data  (wr_data),
      .busy     (busy)
   );

   spi_cp_rd_slot #(.BW(BYTE_W), .NB(WORD_BYTES)) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (~cs_act),
      .byte_done  (rd_done),
      .rd_valid   (rd_valid),
      .rd_ready   (rd_ready),
      .rd_data    (rd_data),
      .irq_n      (irq_n),
      .cur_byte   (rd_byte),
      .word_start (rd_word_start),
      .fresh      (rd_fresh)
   );

   // one shift register serves both directions
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase  <= PH_CMD;
         bitcnt <= '0;
         shreg  <= '0;
      end else if (!cs_act) begin
         phase  <= PH_CMD;
         bitcnt <= '0;
         shreg  <= '0;
      end else if (rise) begin
         bitcnt <= byte_end ? '0 : bitcnt + 1'b1;
         unique case (phase)
            PH_CMD: begin
               shreg <= nxt_byte;
               if (byte_end) begin
                  if (nxt_byte[BYTE_W-1]) begin
                     phase <= PH_RD;
                     shreg <= rd_byte;
                  end else begin
                     phase <= PH_WR;
                  end
               end
            end
            PH_WR:   shreg <= nxt_byte;
            default: ;
         endcase
      end else if (fall && phase == PH_RD) begin
         if (bitcnt != '0)        shreg <= {shreg[BYTE_W-2:0], 1'b0};
         else if (!rd_word_start) shreg <= rd_byte;
      end else if (rd_fresh && phase == PH_RD && bitcnt == '0 && rd_word_start) begin
         shreg <= rd_byte;
      end
   end

   assign spi_miso = (cs_act && phase == PH_RD) ? shreg[BYTE_W-1] : 1'b0;

   // R8: a write word can only appear out of a write transaction
   a_r8_word_from_write: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wr_valid) |-> ($past(phase) == PH_WR));

   // R9: deselect returns the framing to a fresh command byte
   a_r9_deselect_resets: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_act |=> (phase == PH_CMD && bitcnt == '0));

   // R8: no MISO activity outside a read transaction
   a_r8_miso_quiet_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_CMD) |-> !spi_miso);
endmodule

// File: tb/sim_spi_ctrl_port.sv
`timescale 1ns/1ps
module sim_spi_ctrl_port;
   localparam time HALF = 40ns;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        spi_cs_n = 1'b1, spi_sclk = 1'b0, spi_mosi = 1'b0;
   logic        spi_miso, busy, irq_n, wr_valid, rd_ready;
   logic        wr_ready = 1'b1, rd_valid = 1'b0;
   logic [31:0] wr_data, rd_data = '0;

   int checks = 0;
   int errors = 0;
   int ngot = 0;
   logic [31:0] got [16];
   logic miso_seen;

   always #2 clk = ~clk;

   spi_ctrl_port u0 (
      .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
      .spi_mosi(spi_mosi), .spi_miso(spi_miso), .busy(busy), .irq_n(irq_n),
      .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
      .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data)
   );

   // capture accepted write words just before the accepting edge
   always @(negedge clk) begin
      if (rst_n && wr_valid && wr_ready && ngot < 16) begin
         got[ngot] = wr_data;
         ngot++;
      end
   end

   task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic spi_begin();
      @(negedge clk);
      spi_cs_n = 1'b0;
      #HALF;
   endtask

   task automatic spi_end();
      #HALF;
      spi_cs_n = 1'b1;
      #(HALF*2);
   endtask

   task automatic spi_bits(input int n, input logic [7:0] tx, output logic [7:0] rx);
      rx = '0;
      for (int i = 7; i > 7 - n; i--) begin
         spi_mosi = tx[i];
         #HALF;
         rx[i] = spi_miso;
         if (spi_miso) miso_seen = 1'b1;
         spi_sclk = 1'b1;
         #HALF;
         spi_sclk = 1'b0;
      end
   endtask

   task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
      spi_bits(8, tx, rx);
   endtask

   task automatic push_word(input logic [31:0] w);
      @(negedge clk);
      rd_data  = w;
      rd_valid = 1'b1;
      while (!rd_ready) @(negedge clk);
      @(posedge clk);
      #1 rd_valid = 1'b0;
   endtask

   task automatic t_reset();
      chk(irq_n == 1'b1,    "R1 irq_n", 32'(irq_n), 32'h1);
      chk(busy == 1'b0,     "R1 busy", 32'(busy), 32'h0);
      chk(wr_valid == 1'b0, "R1 wr_valid", 32'(wr_valid), 32'h0);
      chk(spi_miso == 1'b0, "R1 miso", 32'(spi_miso), 32'h0);
      chk(rd_ready == 1'b1, "R1 rd_ready", 32'(rd_ready), 32'h1);
   endtask

   task automatic t_write_two_words();
      logic [7:0] rx;
      logic [7:0] data [8] = '{8'h12, 8'h34, 8'h56, 8'h78, 8'h9A, 8'hBC, 8'hDE, 8'hF0};
      int base = ngot;
      wr_ready  = 1'b1;
      miso_seen = 1'b0;
      spi_begin();
      spi_byte(8'h00, rx);
      for (int i = 0; i < 8; i++) spi_byte(data[i], rx);
      spi_end();
      chk(ngot == base + 2, "R3 word count", 32'(ngot - base), 32'd2);
      chk(got[base] == 32'h12345678, "R2 R3 first word", got[base], 32'h12345678);
      chk(got[base+1] == 32'h9ABCDEF0, "R3 second word", got[base+1], 32'h9ABCDEF0);
      chk(miso_seen == 1'b0, "R8 miso during write", 32'(miso_seen), 32'h0);
   endtask

   task automatic t_busy();
      logic [7:0] rx;
      int base = ngot;
      @(posedge clk); #1 wr_ready = 1'b0;
      spi_begin();
      spi_byte(8'h01, rx);
      spi_byte(8'hA1, rx); spi_byte(8'hB2, rx); spi_byte(8'hC3, rx); spi_byte(8'hD4, rx);
      spi_end();
      chk(busy == 1'b1, "R4 busy set", 32'(busy), 32'h1);
      chk(wr_data == 32'hA1B2C3D4, "R3 held data", wr_data, 32'hA1B2C3D4);
      repeat (20) @(negedge clk);
      chk(busy == 1'b1 && wr_valid == 1'b1, "R10 word kept after deselect", 32'(busy), 32'h1);
      @(posedge clk); #1 wr_ready = 1'b1;
      @(negedge clk);
      chk(busy == 1'b1, "R4 busy before accept edge", 32'(busy), 32'h1);
      @(posedge clk);
      @(negedge clk);
      chk(busy == 1'b0, "R4 busy released", 32'(busy), 32'h0);
      chk(ngot == base + 1 && got[base] == 32'hA1B2C3D4, "R10 word delivered", got[base], 32'hA1B2C3D4);
   endtask

   task automatic t_read_one();
      logic [7:0] rx;
      logic [31:0] w = 32'hA5C30F81;
      int base = ngot;
      push_word(w);
      repeat (3) @(negedge clk);
      chk(irq_n == 1'b0, "R5 irq asserted", 32'(irq_n), 32'h0);
      chk(rd_ready == 1'b0, "R5 slot full", 32'(rd_ready), 32'h0);
      spi_begin();
      spi_byte(8'h80, rx);
      for (int b = 3; b >= 0; b--) begin
         spi_byte(8'hFF, rx);
         chk(rx == w[8*b +: 8], "R6 read byte", 32'(rx), 32'(w[8*b +: 8]));
      end
      #(HALF/2);
      chk(irq_n == 1'b1, "R7 irq released after last bit", 32'(irq_n), 32'h1);
      spi_end();
      chk(ngot == base, "R8 mosi ignored in read", 32'(ngot - base), 32'h0);
      chk(rd_ready == 1'b1, "R5 slot empty", 32'(rd_ready), 32'h1);
   endtask

   task automatic t_read_two();
      logic [7:0] rx;
      logic [31:0] w1 = 32'h0123CAFE;
      logic [31:0] w2 = 32'hFEDC5A3C;
      push_word(w1);
      fork
         push_word(w2);
      join_none
      repeat (3) @(negedge clk);
      spi_begin();
      spi_byte(8'hC7, rx);
      for (int b = 3; b >= 0; b--) begin
         spi_byte(8'h00, rx);
         chk(rx == w1[8*b +: 8], "R6 first word byte", 32'(rx), 32'(w1[8*b +: 8]));
      end
      #(HALF/2);
      chk(irq_n == 1'b0, "R7 irq reasserted for queued word", 32'(irq_n), 32'h0);
      for (int b = 3; b >= 0; b--) begin
         spi_byte(8'h00, rx);
         chk(rx == w2[8*b +: 8], "R7 second word byte", 32'(rx), 32'(w2[8*b +: 8]));
      end
      #(HALF/2);
      chk(irq_n == 1'b1, "R7 irq released after second word", 32'(irq_n), 32'h1);
      spi_end();
   endtask

   task automatic t_abort();
      logic [7:0] rx;
      int base = ngot;
      wr_ready = 1'b1;
      spi_begin();
      spi_byte(8'h00, rx);
      spi_byte(8'h11, rx);
      spi_byte(8'h22, rx);
      spi_bits(3, 8'hE0, rx);
      spi_end();
      chk(ngot == base && wr_valid == 1'b0, "R9 partial word dropped", 32'(ngot - base), 32'h0);
      spi_begin();
      spi_bits(5, 8'hF8, rx);
      spi_end();
      spi_begin();
      spi_byte(8'h00, rx);
      spi_byte(8'h0A, rx); spi_byte(8'h0B, rx); spi_byte(8'h0C, rx); spi_byte(8'h0D, rx);
      spi_end();
      chk(ngot == base + 1, "R9 one word after abort", 32'(ngot - base), 32'h1);
      chk(got[base] == 32'h0A0B0C0D, "R9 fresh framing", got[base], 32'h0A0B0C0D);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      t_reset();
      t_write_two_words();
      t_busy();
      t_read_one();
      t_read_two();
      t_abort();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(4ns * 150000);
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule